// File: doc/BRIEF.md
# Two's-Complement Adder-Subtractor with Status Flags

This block is a purely combinational arithmetic unit for two m-bit operands. A single mode input selects between addition and subtraction. Subtraction reuses the adder path: the second operand is inverted bit by bit and the carry input supplies the "+1" of the two's complement. The m-bit result drops any carry out of the top bit. Four status outputs accompany the result: carry, signed overflow, zero and negative.

The carry flag uses the inverted-borrow convention in subtract mode. A 1 means no borrow occurred and a 0 means a borrow occurred. For the same reason, the carry input acts as an active-low borrow input when subtracting. Because of this, words wider than m bits can be added or subtracted one m-bit slice at a time. The carry output of the lower slice is fed into the carry input of the next slice, and the overflow flag of the top slice is valid for the whole word.

Internally the carries are formed by lookahead groups of a parameterised size. The groups are chained by their group generate and propagate terms. The width m is a parameter with default 8.

Top module: `addsub_flags`

## Requirements
- R1: With sub_mode = 0, result equals (op_a + op_b + carry_in) modulo 2^m, with the operands and the result taken as unsigned and carry_in weighted 1.
- R2: With sub_mode = 1, result equals (op_a − op_b − (1 − carry_in)) modulo 2^m. carry_in = 1 means no borrow enters and carry_in = 0 means a borrow of 1 enters.
- R3: With sub_mode = 0, flag_carry is 1 exactly when op_a + op_b + carry_in ≥ 2^m, taken as unsigned values.
- R4: With sub_mode = 1, flag_carry is 1 exactly when no borrow occurs, that is when op_a − op_b − (1 − carry_in) ≥ 0 as unsigned values. It is 0 when a borrow occurs.
- R5: With sub_mode = 0, flag_ovf is 1 exactly when both operands have sign bit 0 and the result has sign bit 1, or both operands have sign bit 1 and the result has sign bit 0. This equals the signed sum leaving the range −2^(m−1) to 2^(m−1)−1.
- R6: With sub_mode = 1, flag_ovf is 1 exactly when the sign bits differ and the result's sign bit differs from that of op_a. This covers A negative with B non-negative and a non-negative result, and A non-negative with B negative and a negative result. It equals the signed difference leaving the range −2^(m−1) to 2^(m−1)−1.
- R7: flag_zero is 1 exactly when all m bits of result are 0.
- R8: flag_neg equals result bit m−1.
- R9: A 2m-bit addition or subtraction is obtained in two steps. The first step works on the low halves with the wanted carry_in. The second step works on the high halves in the same mode, with carry_in set to the first step's flag_carry. The concatenated results, the final flag_carry and the final flag_ovf then match the 2m-bit values defined by R1 to R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand (minuend when subtracting) |
| op_b | input | WIDTH | Second operand (subtrahend when subtracting) |
| sub_mode | input | 1 | 0 selects addition, 1 selects subtraction |
| carry_in | input | 1 | Carry input when adding, active-low borrow input when subtracting |
| result | output | WIDTH | m-bit sum or difference, top carry dropped |
| flag_carry | output | 1 | Carry out when adding, inverted borrow when subtracting |
| flag_ovf | output | 1 | Signed overflow of the selected operation |
| flag_zero | output | 1 | Result is all zeros |
| flag_neg | output | 1 | Sign bit of the result |

## Verification
The carry and overflow flags are produced by separate logic, and both can assert on the same operation. An example is a negative-plus-negative sum that wraps, or a subtraction of a negative value from a non-negative one that both borrows and leaves the range. Zero can likewise coincide with carry when a sum wraps exactly to 0. These coincidences are forced in the 4-bit instance by walking every operand pair, every mode and every carry input. In the 8-bit instance they are forced by directed extremes such as −128 − 1 and 127 + 1, mixed with seeded random values. Each output is judged separately against an integer model that computes the unsigned and signed results independently, so a flag that is right alone but wrong in combination is reported.

// File: rtl/addsub_pkg.sv
// Package: shared constants and types for the adder-subtractor.
// Assumes: consumers import it; nothing here is synthesised on its own.
package addsub_pkg;

    // Operation select encoding used on sub_mode.
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } addsub_op_e;

    // Default width of one carry-lookahead group.
    localparam int unsigned DEF_GROUP_W = 4;

endpackage

// File: rtl/addsub_operand.sv
// Module: addsub_operand
// Conditions the second operand: passes it through when adding and inverts
// every bit when subtracting, so that together with the carry input the
// adder sees the two's complement of op_b.
// Assumes: mode encoding from addsub_pkg; purely combinational.
module addsub_operand
    import addsub_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] b_in,
    input  logic             mode,
    output logic [WIDTH-1:0] b_eff
);

    // Purpose: select true or complemented operand.
    always_comb begin
        if (addsub_op_e'(mode) == OP_SUB) begin
            b_eff = ~b_in;
        end else begin
            b_eff = b_in;
        end
    end

endmodule

// File: rtl/addsub_cla_group.sv
// Module: addsub_cla_group
// One carry-lookahead group. From per-bit generate and propagate terms and
// the group carry input it forms the carry into every bit of the group,
// each as a flat sum of products, plus the group generate and propagate
// used to chain groups.
// Assumes: GW small (product terms grow with GW squared).
module addsub_cla_group #(
    parameter int unsigned GW = 4
) (
    input  logic [GW-1:0] gen,
    input  logic [GW-1:0] prop,
    input  logic          cin,
    output logic [GW-1:0] bit_cin,
    output logic          grp_gen,
    output logic          grp_prop
);

    // Purpose: carry into bit i from cin and lower generate terms.
    always_comb begin
        logic term;
        logic prod;
        bit_cin[0] = cin;
        for (int i = 1; i < GW; i++) begin
            term = cin;
            for (int k = 0; k < i; k++) begin
                term = term & prop[k];
            end
            for (int j = 0; j < i; j++) begin
                prod = gen[j];
                for (int k = j + 1; k < i; k++) begin
                    prod = prod & prop[k];
                end
                term = term | prod;
            end
            bit_cin[i] = term;
        end
    end

    // Purpose: group generate and propagate for the chain above.
    always_comb begin
        logic prod;
        grp_prop = 1'b1;
        for (int k = 0; k < GW; k++) begin
            grp_prop = grp_prop & prop[k];
        end
        grp_gen = 1'b0;
        for (int j = 0; j < GW; j++) begin
            prod = gen[j];
            for (int k = j + 1; k < GW; k++) begin
                prod = prod & prop[k];
            end
            grp_gen = grp_gen | prod;
        end
    end

endmodule

// File: rtl/addsub_cla_adder.sv
// Module: addsub_cla_adder
// WIDTH-bit adder with carry input, built from lookahead groups of GW bits.
// Operands are padded with zeros up to a whole number of groups; padded
// bits generate and propagate nothing, so the carry into bit WIDTH is the
// true carry out. Groups are chained through their generate/propagate.
// Assumes: GW >= 1; WIDTH >= 1.
module addsub_cla_adder #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned GW    = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    localparam int unsigned NGRP  = (WIDTH + GW - 1) / GW;
    localparam int unsigned PAD_W = NGRP * GW;

    logic [PAD_W-1:0] a_pad;
    logic [PAD_W-1:0] b_pad;
    logic [PAD_W-1:0] gen;
    logic [PAD_W-1:0] prop;
    logic [PAD_W:0]   carry;
    logic [NGRP:0]    grp_cin;
    logic [NGRP-1:0]  grp_gen;
    logic [NGRP-1:0]  grp_prop;

    // Purpose: zero-extend operands to whole groups.
    always_comb begin
        a_pad = '0;
        b_pad = '0;
        a_pad[WIDTH-1:0] = a;
        b_pad[WIDTH-1:0] = b;
    end

    // Purpose: per-bit generate and propagate terms.
    always_comb begin
        gen  = a_pad & b_pad;
        prop = a_pad ^ b_pad;
    end

    assign grp_cin[0] = cin;

    for (genvar g = 0; g < NGRP; g++) begin : gen_grp
        addsub_cla_group #(
            .GW (GW)
        ) i_group (
            .gen      (gen[g*GW +: GW]),
            .prop     (prop[g*GW +: GW]),
            .cin      (grp_cin[g]),
            .bit_cin  (carry[g*GW +: GW]),
            .grp_gen  (grp_gen[g]),
            .grp_prop (grp_prop[g])
        );
        // Purpose: carry into the next group.
        assign grp_cin[g+1] = grp_gen[g] | (grp_prop[g] & grp_cin[g]);
    end

    assign carry[PAD_W] = grp_cin[NGRP];

    // Purpose: sum bits and carry out of the WIDTH-bit range.
    always_comb begin
        sum  = prop[WIDTH-1:0] ^ carry[WIDTH-1:0];
        cout = carry[WIDTH];
    end

endmodule

// File: rtl/addsub_flag_unit.sv
// Module: addsub_flag_unit
// Derives the status flags. Overflow uses the sign rules of the selected
// operation on the original operand signs; carry passes through unchanged,
// which already is the inverted borrow when the adder sees ~B.
// Assumes: res is the WIDTH-bit adder output for the same operands.
module addsub_flag_unit
    import addsub_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             sign_a,
    input  logic             sign_b,
    input  logic [WIDTH-1:0] res,
    input  logic             mode,
    input  logic             adder_cout,
    output logic             flag_carry,
    output logic             flag_ovf,
    output logic             flag_zero,
    output logic             flag_neg
);

    logic sign_r;

    assign sign_r = res[WIDTH-1];

    // Purpose: operation-specific signed overflow rule.
    always_comb begin
        if (addsub_op_e'(mode) == OP_SUB) begin
            flag_ovf = (sign_a != sign_b) && (sign_r != sign_a);
        end else begin
            flag_ovf = (sign_a == sign_b) && (sign_r != sign_a);
        end
    end

    // Purpose: carry, zero and negative flags.
    always_comb begin
        flag_carry = adder_cout;
        flag_zero  = ~(|res);
        flag_neg   = sign_r;
    end

endmodule

// File: rtl/addsub_flags.sv
// Module: addsub_flags (top)
// Combinational two's-complement adder-subtractor with carry, overflow,
// zero and negative flags. Subtraction adds the complemented op_b; the
// carry input is a carry when adding and an active-low borrow when
// subtracting, so slices can be chained for wider words.
// Assumes: no clock or reset; outputs settle within one combinational path.
module addsub_flags
    import addsub_pkg::*;
#(
    parameter int unsigned WIDTH   = 8,
    parameter int unsigned GROUP_W = DEF_GROUP_W
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             sub_mode,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             flag_carry,
    output logic             flag_ovf,
    output logic             flag_zero,
    output logic             flag_neg
);

    logic [WIDTH-1:0] b_eff;
    logic             adder_cout;

    addsub_operand #(
        .WIDTH (WIDTH)
    ) i_operand (
        .b_in  (op_b),
        .mode  (sub_mode),
        .b_eff (b_eff)
    );

    addsub_cla_adder #(
        .WIDTH (WIDTH),
        .GW    (GROUP_W)
    ) i_adder (
        .a    (op_a),
        .b    (b_eff),
        .cin  (carry_in),
        .sum  (result),
        .cout (adder_cout)
    );

    addsub_flag_unit #(
        .WIDTH (WIDTH)
    ) i_flags (
        .sign_a     (op_a[WIDTH-1]),
        .sign_b     (op_b[WIDTH-1]),
        .res        (result),
        .mode       (sub_mode),
        .adder_cout (adder_cout),
        .flag_carry (flag_carry),
        .flag_ovf   (flag_ovf),
        .flag_zero  (flag_zero),
        .flag_neg   (flag_neg)
    );

endmodule

// File: rtl/addsub_flags_checker.sv
// Module: addsub_flags_checker
// Immediate assertions relating the top-level ports of addsub_flags to
// arithmetic written independently of the lookahead structure.
// Assumes: bound to every addsub_flags instance; combinational inputs.
module addsub_flags_checker #(
    parameter int unsigned WIDTH = 8
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             sub_mode,
    input logic             carry_in,
    input logic [WIDTH-1:0] result,
    input logic             flag_carry,
    input logic             flag_ovf,
    input logic             flag_zero,
    input logic             flag_neg
);

    logic [WIDTH:0] add_ext;
    logic [WIDTH:0] sub_ext;
    logic [WIDTH:0] sadd_ext;
    logic [WIDTH:0] ssub_ext;

    // Purpose: reference sums widened by one bit.
    always_comb begin
        add_ext  = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
        sub_ext  = {1'b0, op_a} - {1'b0, op_b} - {{WIDTH{1'b0}}, ~carry_in};
        sadd_ext = {op_a[WIDTH-1], op_a} + {op_b[WIDTH-1], op_b}
                   + {{WIDTH{1'b0}}, carry_in};
        ssub_ext = {op_a[WIDTH-1], op_a} - {op_b[WIDTH-1], op_b}
                   - {{WIDTH{1'b0}}, ~carry_in};
    end

    // Purpose: check ports against the widened references.
    always_comb begin
        if (!sub_mode) begin
            a_r1_add_result: assert (result == add_ext[WIDTH-1:0]);
            a_r3_add_carry: assert (flag_carry == add_ext[WIDTH]);
            a_r5_add_ovf: assert (flag_ovf == (sadd_ext[WIDTH] != sadd_ext[WIDTH-1]));
        end else begin
            a_r2_sub_result: assert (result == sub_ext[WIDTH-1:0]);
            a_r4_sub_no_borrow: assert (flag_carry == !sub_ext[WIDTH]);
            a_r6_sub_ovf: assert (flag_ovf == (ssub_ext[WIDTH] != ssub_ext[WIDTH-1]));
        end
        a_r7_zero_not_neg: assert (!(flag_zero && flag_neg));
    end

endmodule

bind addsub_flags addsub_flags_checker #(
    .WIDTH (WIDTH)
) i_addsub_flags_checker (
    .op_a       (op_a),
    .op_b       (op_b),
    .sub_mode   (sub_mode),
    .carry_in   (carry_in),
    .result     (result),
    .flag_carry (flag_carry),
    .flag_ovf   (flag_ovf),
    .flag_zero  (flag_zero),
    .flag_neg   (flag_neg)
);

// File: tb/test_addsub_flags.sv
// Bench: exhaustive 4-bit sweep, slice chaining, and seeded random plus
// directed corners on the default 8-bit width, all against an integer model.
module test_addsub_flags;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // 4-bit instance
    logic [3:0] a4, b4, r4;
    logic       s4, c4, fc4, fv4, fz4, fn4;

    addsub_flags #(
        .WIDTH (4)
    ) i_addsub_flags (
        .op_a       (a4),
        .op_b       (b4),
        .sub_mode   (s4),
        .carry_in   (c4),
        .result     (r4),
        .flag_carry (fc4),
        .flag_ovf   (fv4),
        .flag_zero  (fz4),
        .flag_neg   (fn4)
    );

    // 8-bit instance, default parameters
    logic [7:0] a8, b8, r8;
    logic       s8, c8, fc8, fv8, fz8, fn8;

    addsub_flags i_addsub_flags_w8 (
        .op_a       (a8),
        .op_b       (b8),
        .sub_mode   (s8),
        .carry_in   (c8),
        .result     (r8),
        .flag_carry (fc8),
        .flag_ovf   (fv8),
        .flag_zero  (fz8),
        .flag_neg   (fn8)
    );

    // Integer reference model for width w.
    task automatic ref_calc(input int w, input int a, input int b, input int sub,
                            input int cin, output int r, output int c,
                            output int v, output int z, output int n);
        int m, half, sa, sb, raw, sraw;
        m    = 1 << w;
        half = m / 2;
        sa   = (a >= half) ? a - m : a;
        sb   = (b >= half) ? b - m : b;
        if (sub == 0) begin
            raw  = a + b + cin;
            sraw = sa + sb + cin;
            c    = (raw >= m) ? 1 : 0;
        end else begin
            raw  = a - b - (1 - cin);
            sraw = sa - sb - (1 - cin);
            c    = (raw >= 0) ? 1 : 0;
        end
        r = ((raw % m) + m) % m;
        v = (sraw < -half || sraw > half - 1) ? 1 : 0;
        z = (r == 0) ? 1 : 0;
        n = (r >= half) ? 1 : 0;
    endtask

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input int w, input int a, input int b, input int sub,
                             input int cin, input int r, input int c, input int v,
                             input int z, input int n);
        int er, ec, ev, ez, en;
        ref_calc(w, a, b, sub, cin, er, ec, ev, ez, en);
        cmp(sub ? "R2" : "R1", "result", r, er);
        cmp(sub ? "R4" : "R3", "carry", c, ec);
        cmp(sub ? "R6" : "R5", "overflow", v, ev);
        cmp("R7", "zero", z, ez);
        cmp("R8", "negative", n, en);
    endtask

    // Drive 4-bit instance at negedge, check at the next posedge.
    task automatic run4(input int a, input int b, input int sub, input int cin);
        @(negedge clk);
        a4 = 4'(a); b4 = 4'(b); s4 = 1'(sub); c4 = 1'(cin);
        @(posedge clk);
        check_all(4, a, b, sub, cin, int'(r4), int'(fc4), int'(fv4), int'(fz4), int'(fn4));
    endtask

    task automatic run8(input int a, input int b, input int sub, input int cin);
        @(negedge clk);
        a8 = 8'(a); b8 = 8'(b); s8 = 1'(sub); c8 = 1'(cin);
        @(posedge clk);
        check_all(8, a, b, sub, cin, int'(r8), int'(fc8), int'(fv8), int'(fz8), int'(fn8));
    endtask

    // R9: 8-bit operation done as two 4-bit slices on the 4-bit instance.
    task automatic chain8(input int a, input int b, input int sub, input int cin);
        int lo, carry_mid, er, ec, ev, ez, en;
        @(negedge clk);
        a4 = 4'(a); b4 = 4'(b); s4 = 1'(sub); c4 = 1'(cin);
        @(posedge clk);
        lo        = int'(r4);
        carry_mid = int'(fc4);
        @(negedge clk);
        a4 = 4'(a >> 4); b4 = 4'(b >> 4); c4 = 1'(carry_mid);
        @(posedge clk);
        ref_calc(8, a, b, sub, cin, er, ec, ev, ez, en);
        cmp("R9", "chained result", int'(r4) * 16 + lo, er);
        cmp("R9", "chained carry", int'(fc4), ec);
        cmp("R9", "chained overflow", int'(fv4), ev);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        for (int cyc = 0; cyc < WATCHDOG; cyc++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int ra, rb, rs, rc;
        a4 = '0; b4 = '0; s4 = 1'b0; c4 = 1'b0;
        a8 = '0; b8 = '0; s8 = 1'b0; c8 = 1'b0;
        void'($urandom(32'h5eed_1234));
        @(posedge clk);
        // Idle state: all-zero inputs give zero result, zero flag set (R7).
        cmp("R7", "idle zero flag", int'(fz8), 1);
        cmp("R1", "idle result", int'(r8), 0);

        // Exhaustive 4-bit sweep: R1..R8.
        for (int sub = 0; sub < 2; sub++)
            for (int cin = 0; cin < 2; cin++)
                for (int a = 0; a < 16; a++)
                    for (int b = 0; b < 16; b++)
                        run4(a, b, sub, cin);

        // Directed 8-bit corners: overflow with carry, wrap to zero, borrows.
        run8(127, 1, 0, 0);    // R5 positive overflow
        run8(128, 128, 0, 0);  // R3 carry and R5 overflow, result zero
        run8(255, 1, 0, 0);    // R3 carry, R7 zero
        run8(255, 255, 0, 1);  // R1 with carry in
        run8(128, 1, 1, 1);    // R6 overflow on subtract
        run8(0, 128, 1, 1);    // R6 overflow, R4 borrow
        run8(0, 0, 1, 0);      // R2 borrow in gives all ones, R4 borrow
        run8(5, 5, 1, 1);      // R4 no borrow, R7 zero
        run8(0, 0, 1, 1);      // R4 no borrow at zero
        run8(127, 255, 1, 1);  // R6 overflow, R8 negative

        // Seeded random 8-bit vectors.
        for (int i = 0; i < 600; i++) begin
            ra = int'($urandom_range(0, 255));
            rb = int'($urandom_range(0, 255));
            rs = int'($urandom_range(0, 1));
            rc = int'($urandom_range(0, 1));
            run8(ra, rb, rs, rc);
        end

        // R9 chaining: directed then random.
        chain8(8'h0F, 8'h01, 0, 0);
        chain8(8'h10, 8'h01, 1, 1);
        chain8(8'h7F, 8'h01, 0, 0);
        chain8(8'h80, 8'h01, 1, 1);
        for (int i = 0; i < 200; i++) begin
            ra = int'($urandom_range(0, 255));
            rb = int'($urandom_range(0, 255));
            rs = int'($urandom_range(0, 1));
            rc = int'($urandom_range(0, 1));
            chain8(ra, rb, rs, rc);
        end

        finish_run();
    end

endmodule